// File: doc/BRIEF.md
# Word ALU with Full-Word Overflow Register

This block is the arithmetic and logic core of a small 16-bit processor. On each strobe it takes an opcode and two operand words. It produces a result word and a write-back enable, and it updates a 16-bit overflow register that holds the word that spilled out of the operation. Depending on the operation, that spill word is a carry, a borrow mask, the upper half of a product, a remainder, or the bits pushed out by a shift.

Add and subtract have carry-in forms that consume the current overflow word in the same operation. Shifts have OR-in forms that merge the current overflow word into the shifted result. With these forms a wide integer can be added, subtracted or shifted at one operation per word, and no carry is lost between words. Unsigned and signed forms exist for multiply, divide, right shift and greater-than compare. Division is iterative and keeps a busy flag raised while it runs. Every other operation completes in one cycle.

Top module: `word_alu_ovf`

## Requirements
- R1: Opcode encodings on `op_i` are: 0 add, 1 add-with-O, 2 subtract, 3 subtract-with-O, 4 unsigned multiply, 5 signed multiply, 6 unsigned divide, 7 signed divide, 8 and, 9 or, 10 xor, 11 shift left, 12 shift left OR-in, 13 shift right, 14 shift right OR-in, 15 arithmetic shift right, 16 unsigned greater-than, 17 signed greater-than. For every non-divide opcode, `done_o` pulses in the cycle after the accepted strobe, with `result_o` and `ovf_o` valid in that cycle. After reset, `result_o`, `ovf_o`, `done_o`, `wb_o` and `busy_o` are all zero.
- R2: Add returns the low 16 bits of a+b and sets O to 0x0001 when the sum exceeds 16 bits, otherwise to 0x0000.
- R3: Every operation rewrites O, so a plain add that follows a carry-producing add leaves O at 0x0000 when its own sum does not carry.
- R4: Add-with-O returns the low 16 bits of a+b+O and sets O to the bits of that sum above bit 15. Subtract-with-O returns a-b-c, where c is 1 when the incoming O is nonzero, and sets O to 0xFFFF on borrow, otherwise to 0x0000. Chaining these forms gives exact 48-bit and 64-bit sums and differences.
- R5: Subtract returns a-b modulo 2^16 and sets O to 0xFFFF when b > a (unsigned), otherwise to 0x0000.
- R6: The multiplies return the low half of the 32-bit product in `result_o` and the high half in O. The unsigned form treats both operands as unsigned; the signed form treats both as two's complement.
- R7: The shift amount is b[3:0]. Shift left puts the bits that left the top of the word into O, right-aligned. Shift right and arithmetic shift right put the bits that left the bottom into O, left-aligned. Arithmetic shift right fills with copies of a[15]. The OR-in forms OR the incoming O into the shifted result.
- R8: A divide raises `busy_o` for exactly 16 cycles after the accepted strobe. It then pulses `done_o` in the cycle in which `busy_o` falls.
- R9: Divide returns the quotient truncated toward zero and puts the remainder, which takes the sign of the dividend, into O. The signed form treats both operands as two's complement. Division by zero returns 0 with O = 0x0000.
- R10: When `dst_const_i` is high at the strobe, `wb_o` stays low with that operation's `done_o`, and O is still updated. Otherwise `wb_o` equals `done_o`.
- R11: Compares return 0x0001 when true and 0x0000 when false. Compares and the logic operations set O to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 5 | Opcode |
| a_i | input | 16 | First operand (destination side) |
| b_i | input | 16 | Second operand / shift amount |
| dst_const_i | input | 1 | Destination is a constant: suppress write-back |
| result_o | output | 16 | Result word |
| ovf_o | output | 16 | Overflow register O |
| wb_o | output | 1 | Write-back enable, pulses with done |
| done_o | output | 1 | Result valid pulse |
| busy_o | output | 1 | Divide in progress |

## Verification
The assertions assume that `valid_i` is never raised while `busy_o` is high. The divider has no queue, so a strobe during a divide would break the relation between strobes and done pulses that the checks depend on. The stimulus issues one operation at a time and waits until its expected result has been popped from the scoreboard before driving the next strobe. Because of this, no strobe overlaps a running divide. O is carried between operations exactly as a program would carry it, which lets the carry-in forms be exercised by real word chains.

// File: rtl/alu_pkg.sv
package alu_pkg;
    parameter int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_MUL   = 5'd4,
        OP_MULS  = 5'd5,
        OP_DIV   = 5'd6,
        OP_DIVS  = 5'd7,
        OP_AND   = 5'd8,
        OP_OR    = 5'd9,
        OP_XOR   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHLO  = 5'd12,
        OP_SHR   = 5'd13,
        OP_SHRO  = 5'd14,
        OP_ASR   = 5'd15,
        OP_CMPG  = 5'd16,
        OP_CMPGS = 5'd17
    } alu_op_e;

    typedef struct packed {
        word_t res;
        word_t ovf;
    } alu_out_t;

    function automatic logic is_div(alu_op_e op);
        return (op == OP_DIV) || (op == OP_DIVS);
    endfunction

    function automatic word_t neg_word(word_t v);
        return word_t'(0) - v;
    endfunction
endpackage

// File: rtl/alu_comb.sv
module alu_comb
    import alu_pkg::*;
(
    input  alu_op_e  op_i,
    input  word_t    a_i,
    input  word_t    b_i,
    input  word_t    ovf_i,
    output alu_out_t y_o
);
    localparam int W  = WORD_W;
    localparam int W2 = 2 * WORD_W;
    localparam int SW = $clog2(WORD_W);

    logic [W:0]          add_s;
    logic [W+1:0]        adc_s;
    logic [W:0]          sub_d;
    logic [W:0]          sbc_d;
    logic [W2-1:0]       mul_u;
    logic signed [W2-1:0] mul_s;
    logic [W2-1:0]       shl_w;
    logic [W2-1:0]       shr_w;
    logic [W2-1:0]       asr_w;
    logic [SW-1:0]       sh;
    logic                bin;

    always_comb begin
        sh    = b_i[SW-1:0];
        bin   = |ovf_i;
        add_s = {1'b0, a_i} + {1'b0, b_i};
        adc_s = {2'b00, a_i} + {2'b00, b_i} + {2'b00, ovf_i};
        sub_d = {1'b0, a_i} - {1'b0, b_i};
        sbc_d = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, bin};
        mul_u = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        mul_s = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
        shl_w = {{W{1'b0}}, a_i} << sh;
        shr_w = {a_i, {W{1'b0}}} >> sh;
        asr_w = $signed({a_i, {W{1'b0}}}) >>> sh;

        y_o = '0;
        unique case (op_i)
            OP_ADD:   begin y_o.res = add_s[W-1:0]; y_o.ovf = {{(W-1){1'b0}}, add_s[W]}; end
            OP_ADC:   begin y_o.res = adc_s[W-1:0]; y_o.ovf = {{(W-2){1'b0}}, adc_s[W+1:W]}; end
            OP_SUB:   begin y_o.res = sub_d[W-1:0]; y_o.ovf = {W{sub_d[W]}}; end
            OP_SBC:   begin y_o.res = sbc_d[W-1:0]; y_o.ovf = {W{sbc_d[W]}}; end
            OP_MUL:   begin y_o.res = mul_u[W-1:0]; y_o.ovf = mul_u[W2-1:W]; end
            OP_MULS:  begin y_o.res = mul_s[W-1:0]; y_o.ovf = mul_s[W2-1:W]; end
            OP_AND:   y_o.res = a_i & b_i;
            OP_OR:    y_o.res = a_i | b_i;
            OP_XOR:   y_o.res = a_i ^ b_i;
            OP_SHL:   begin y_o.res = shl_w[W-1:0]; y_o.ovf = shl_w[W2-1:W]; end
            OP_SHLO:  begin y_o.res = shl_w[W-1:0] | ovf_i; y_o.ovf = shl_w[W2-1:W]; end
            OP_SHR:   begin y_o.res = shr_w[W2-1:W]; y_o.ovf = shr_w[W-1:0]; end
            OP_SHRO:  begin y_o.res = shr_w[W2-1:W] | ovf_i; y_o.ovf = shr_w[W-1:0]; end
            OP_ASR:   begin y_o.res = asr_w[W2-1:W]; y_o.ovf = asr_w[W-1:0]; end
            OP_CMPG:  y_o.res = {{(W-1){1'b0}}, (a_i > b_i)};
            OP_CMPGS: y_o.res = {{(W-1){1'b0}}, ($signed(a_i) > $signed(b_i))};
            default:  y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_divider.sv
module alu_divider
    import alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  signed_i,
    input  word_t a_i,
    input  word_t b_i,
    output logic  busy_o,
    output logic  last_o,
    output word_t quot_o,
    output word_t rem_o
);
    localparam int W     = WORD_W;
    localparam int STEPS = WORD_W;
    localparam int CW    = $clog2(STEPS);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    word_t         rem_q, quot_q, dvs_q;
    logic          negq_q, negr_q, zero_q;

    logic [W:0]    trial, rem_nx;
    logic          ge;
    word_t         quot_nx;
    word_t         ua, ub;

    always_comb begin
        ua      = (signed_i && a_i[W-1]) ? neg_word(a_i) : a_i;
        ub      = (signed_i && b_i[W-1]) ? neg_word(b_i) : b_i;
        trial   = {rem_q, quot_q[W-1]};
        ge      = trial >= {1'b0, dvs_q};
        rem_nx  = ge ? (trial - {1'b0, dvs_q}) : trial;
        quot_nx = {quot_q[W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            rem_q    <= '0;
            quot_q   <= '0;
            dvs_q    <= '0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
            zero_q   <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            rem_q    <= '0;
            quot_q   <= ua;
            dvs_q    <= ub;
            negq_q   <= signed_i && (a_i[W-1] ^ b_i[W-1]);
            negr_q   <= signed_i && a_i[W-1];
            zero_q   <= (b_i == '0);
        end else if (active_q) begin
            rem_q  <= rem_nx[W-1:0];
            quot_q <= quot_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(STEPS - 1)) active_q <= 1'b0;
        end
    end

    assign busy_o = active_q;
    assign last_o = active_q && (cnt_q == CW'(STEPS - 1));
    assign quot_o = zero_q ? '0 : (negq_q ? neg_word(quot_nx) : quot_nx);
    assign rem_o  = zero_q ? '0 : (negr_q ? neg_word(rem_nx[W-1:0]) : rem_nx[W-1:0]);

    // R8: a new divide is never launched while one runs
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !active_q);
    // R8: the final step always clears the run state
    p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !busy_o);
endmodule

// File: rtl/word_alu_ovf.sv
module word_alu_ovf
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [4:0]  op_i,
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic        dst_const_i,
    output logic [15:0] result_o,
    output logic [15:0] ovf_o,
    output logic        wb_o,
    output logic        done_o,
    output logic        busy_o
);
    alu_op_e  op;
    alu_out_t comb_y;
    logic     accept, div_start, div_busy, div_last;
    word_t    div_q, div_r;
    word_t    result_q, ovf_q;
    logic     done_q, wb_q, dconst_q;

    assign op        = alu_op_e'(op_i);
    assign accept    = valid_i && !div_busy;
    assign div_start = accept && is_div(op);

    alu_comb u_comb (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .ovf_i (ovf_q),
        .y_o   (comb_y)
    );

    alu_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .start_i  (div_start),
        .signed_i (op == OP_DIVS),
        .a_i      (a_i),
        .b_i      (b_i),
        .busy_o   (div_busy),
        .last_o   (div_last),
        .quot_o   (div_q),
        .rem_o    (div_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ovf_q    <= '0;
            done_q   <= 1'b0;
            wb_q     <= 1'b0;
            dconst_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            wb_q   <= 1'b0;
            if (accept && !is_div(op)) begin
                result_q <= comb_y.res;
                ovf_q    <= comb_y.ovf;
                done_q   <= 1'b1;
                wb_q     <= !dst_const_i;
            end else if (div_start) begin
                dconst_q <= dst_const_i;
            end
            if (div_last) begin
                result_q <= div_q;
                ovf_q    <= div_r;
                done_q   <= 1'b1;
                wb_q     <= !dconst_q;
            end
        end
    end

    assign result_o = result_q;
    assign ovf_o    = ovf_q;
    assign done_o   = done_q;
    assign wb_o     = wb_q;
    assign busy_o   = div_busy;

    // R1: input rule - no strobe during a divide
    p_no_strobe_busy_r1: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> !busy_o);
    // R10: write-back only alongside a result
    p_wb_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        wb_o |-> done_o);
    // R10: constant destination suppresses write-back
    p_const_dst_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !busy_o && dst_const_i && !is_div(alu_op_e'(op_i))) |=> (done_o && !wb_o));
    // R2: plain add leaves only 0 or 1 in O
    p_add_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !busy_o && op_i == OP_ADD) |=> (ovf_o <= 16'h0001));
    // R5: subtract leaves an all-zero or all-one O
    p_sub_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !busy_o && op_i == OP_SUB) |=> (ovf_o == 16'h0000 || ovf_o == 16'hFFFF));
    // R11: compares return a flag word
    p_cmp_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !busy_o && (op_i == OP_CMPG || op_i == OP_CMPGS)) |=> (result_o <= 16'h0001 && ovf_o == 16'h0000));
    // R8: the end of a divide delivers its result
    p_div_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);
endmodule

// File: tb/test_word_alu_ovf.sv
`timescale 1ns/1ps
module test_word_alu_ovf;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [4:0]  op_r = '0;
    logic [15:0] a_r = '0, b_r = '0;
    logic        dc_r = 1'b0;
    logic [15:0] result_o, ovf_o;
    logic        wb_o, done_o, busy_o;

    int checks = 0;
    int fails  = 0;
    int busy_cnt = 0;
    logic [15:0] m_o = '0;

    typedef struct {
        logic [15:0] res;
        logic [15:0] ovf;
        logic        wb;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    word_alu_ovf i_word_alu_ovf (
        .clk(clk), .rst(rst), .valid_i(valid), .op_i(op_r), .a_i(a_r), .b_i(b_r),
        .dst_const_i(dc_r), .result_o(result_o), .ovf_o(ovf_o), .wb_o(wb_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor: pop and compare on every result pulse
    always @(negedge clk) begin
        if (busy_o) busy_cnt++;
        if (!rst && done_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected done: actual res=%h ovf=%h expected no result", result_o, ovf_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result_o !== e.res || ovf_o !== e.ovf || wb_o !== e.wb) begin
                    fails++;
                    $display("FAIL %s: actual res=%h ovf=%h wb=%b expected res=%h ovf=%h wb=%b",
                             e.tag, result_o, ovf_o, wb_o, e.res, e.ovf, e.wb);
                end
            end
        end
    end

    // reference built from the requirement text
    task automatic model(input alu_op_e op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] oin, output logic [15:0] r, output logic [15:0] o);
        logic [31:0] s;
        int n, sa, sbv, q, rm, bi;
        longint p;
        n = b % 16;
        r = '0; o = '0;
        case (op)
            OP_ADD:  begin s = a + b; r = s[15:0]; o = (s > 32'hFFFF) ? 16'h1 : 16'h0; end
            OP_ADC:  begin s = a + b + oin; r = s[15:0]; o = s[31:16]; end
            OP_SUB:  begin r = a - b; o = (b > a) ? 16'hFFFF : 16'h0; end
            OP_SBC:  begin bi = (oin != 0) ? 1 : 0; r = a - b - bi[15:0];
                           o = (int'(a) < int'(b) + bi) ? 16'hFFFF : 16'h0; end
            OP_MUL:  begin s = a * b; r = s[15:0]; o = s[31:16]; end
            OP_MULS: begin p = longint'($signed(a)) * longint'($signed(b)); r = p[15:0]; o = p[31:16]; end
            OP_DIV:  begin if (b != 0) begin r = a / b; o = a % b; end end
            OP_DIVS: begin
                sa = $signed(a); sbv = $signed(b);
                if (sbv != 0) begin q = sa / sbv; rm = sa % sbv; r = q[15:0]; o = rm[15:0]; end
            end
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_SHL, OP_SHLO: begin
                s = {16'h0, a};
                for (int k = 0; k < n; k++) s = s * 2;
                r = s[15:0]; o = s[31:16];
                if (op == OP_SHLO) r = r | oin;
            end
            OP_SHR, OP_SHRO, OP_ASR: begin
                s = {a, 16'h0};
                for (int k = 0; k < n; k++) s = {(op == OP_ASR) ? s[31] : 1'b0, s[31:1]};
                r = s[31:16]; o = s[15:0];
                if (op == OP_SHRO) r = r | oin;
            end
            OP_CMPG:  r = (a > b) ? 16'h1 : 16'h0;
            OP_CMPGS: r = ($signed(a) > $signed(b)) ? 16'h1 : 16'h0;
            default: ;
        endcase
    endtask

    task automatic send(input alu_op_e op, input logic [15:0] a, input logic [15:0] b,
                        input logic dc, input logic [15:0] er, input logic [15:0] eo, input string tag);
        exp_t e;
        e.res = er; e.ovf = eo; e.wb = !dc; e.tag = tag;
        sb.push_back(e);
        m_o = eo;
        @(negedge clk);
        valid = 1'b1; op_r = op; a_r = a; b_r = b; dc_r = dc;
        @(negedge clk);
        valid = 1'b0;
        wait (sb.size() == 0);
    endtask

    task automatic run(input alu_op_e op, input logic [15:0] a, input logic [15:0] b,
                       input logic dc, input string tag);
        logic [15:0] r, o;
        model(op, a, b, m_o, r, o);
        send(op, a, b, dc, r, o, tag);
    endtask

    task automatic run_div(input alu_op_e op, input logic [15:0] a, input logic [15:0] b,
                           input logic dc, input string tag);
        busy_cnt = 0;
        run(op, a, b, dc, tag);
        checks++;
        if (busy_cnt != 16) begin
            fails++;
            $display("FAIL R8 busy length: actual %0d expected 16", busy_cnt);
        end
    endtask

    // wide add through add / add-with-O, expected from a 65-bit sum
    task automatic chain_add(input logic [63:0] x, input logic [63:0] y, input int words, input string tag);
        logic [64:0] full, part, mask;
        full = {1'b0, x} + {1'b0, y};
        for (int i = 0; i < words; i++) begin
            mask = (65'd1 << (16 * (i + 1))) - 65'd1;
            part = ({1'b0, x} & mask) + ({1'b0, y} & mask);
            send((i == 0) ? OP_ADD : OP_ADC, x[16*i +: 16], y[16*i +: 16], 1'b0,
                 full[16*i +: 16], {15'h0, part[16*(i+1)]}, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog: actual run hung expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (result_o !== 16'h0 || ovf_o !== 16'h0 || done_o !== 1'b0 || wb_o !== 1'b0 || busy_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: actual res=%h ovf=%h done=%b wb=%b busy=%b expected all zero",
                     result_o, ovf_o, done_o, wb_o, busy_o);
        end

        run(OP_ADD, 16'h1234, 16'h1111, 1'b0, "R2 add no carry");
        run(OP_ADD, 16'hFFFF, 16'h0001, 1'b0, "R2 add carry");
        run(OP_ADD, 16'h0000, 16'h0000, 1'b0, "R3 add clears pending carry");
        run(OP_SUB, 16'h0005, 16'h0007, 1'b0, "R5 sub borrow");
        run(OP_SUB, 16'h0007, 16'h0005, 1'b0, "R5 sub no borrow");

        chain_add(64'h0000_FFFF_FFFF, 64'h0000_0000_0001, 3, "R4 48-bit chain");
        chain_add(64'h0000_0000_FFFF_FFFF, 64'h1, 4, "R4 64-bit chain carry to word2");
        chain_add(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4, "R4 64-bit chain full wrap");
        chain_add(64'h8000_7FFF_C000_1234, 64'h8000_8001_4000_EDCC, 4, "R4 64-bit chain mixed");
        run(OP_ADC, 16'hFFFF, 16'hFFFF, 1'b0, "R4 adc carry word");
        send(OP_SUB, 16'h0000, 16'h0001, 1'b0, 16'hFFFF, 16'hFFFF, "R4 sbc chain low");
        send(OP_SBC, 16'h0001, 16'h0000, 1'b0, 16'h0000, 16'h0000, "R4 sbc chain high");
        run(OP_SUB, 16'h0000, 16'h0001, 1'b0, "R4 sbc setup");
        run(OP_SBC, 16'h0000, 16'hFFFF, 1'b0, "R4 sbc borrow through");

        run(OP_MUL,  16'hFFFF, 16'hFFFF, 1'b0, "R6 mul unsigned");
        run(OP_MULS, 16'hFFFF, 16'hFFFF, 1'b0, "R6 muls minus one squared");
        run(OP_MULS, 16'h8000, 16'h0002, 1'b0, "R6 muls negative");

        run(OP_SHL,  16'h8765, 16'h0004, 1'b0, "R7 shl low word");
        send(OP_SHLO, 16'h1234, 16'h0004, 1'b0, 16'h2348, 16'h0001, "R7 shlo high word");
        run(OP_SHR,  16'h1234, 16'h0004, 1'b0, "R7 shr high word");
        send(OP_SHRO, 16'h8765, 16'h0004, 1'b0, 16'h4876, 16'h5000, "R7 shro low word");
        run(OP_ASR,  16'h8001, 16'h0001, 1'b0, "R7 asr by one");
        run(OP_ASR,  16'h8000, 16'h0014, 1'b0, "R7 asr amount uses b[3:0]");
        run(OP_SHL,  16'hABCD, 16'h0000, 1'b0, "R7 shl by zero");

        run_div(OP_DIV,  16'd100, 16'd7, 1'b0, "R9 div unsigned");
        run_div(OP_DIV,  16'h1234, 16'h0000, 1'b0, "R9 div by zero");
        run_div(OP_DIVS, 16'hFF9C, 16'd7, 1'b0, "R9 divs negative dividend");
        run_div(OP_DIVS, 16'd100, 16'hFFF9, 1'b0, "R9 divs negative divisor");
        run_div(OP_DIVS, 16'h8000, 16'hFFFF, 1'b1, "R10 divs constant destination");

        run(OP_ADD, 16'hFFFF, 16'h0002, 1'b1, "R10 add constant destination updates O");
        run(OP_CMPG,  16'hFFFF, 16'h0001, 1'b0, "R11 cmpg unsigned true");
        run(OP_CMPGS, 16'hFFFF, 16'h0001, 1'b0, "R11 cmpgs signed false");
        run(OP_CMPG,  16'h0003, 16'h0003, 1'b0, "R11 cmpg equal false");
        run(OP_AND, 16'hF0F0, 16'h3C3C, 1'b0, "R11 and");
        run(OP_OR,  16'hF0F0, 16'h0F01, 1'b0, "R11 or");
        run(OP_XOR, 16'hFFFF, 16'h1234, 1'b0, "R11 xor");

        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule